// File: doc/BRIEF.md
# Multiphase Interleaving Clock Divider

This block derives the phase clocks for a hierarchical time-interleaved sampler from one fast clock. Each rising edge of `clk` stands for one period of the fast input clock. The outputs are registered phase vectors that downstream logic uses as sampling enables.

There are three kinds of output, all built from the same clock:
- A four-phase one-hot ring (`quad_np`) gives non-overlapping quarter-rate pulses that steer a one-to-four demultiplexer.
- A four-phase Johnson-style generator (`quad_50`) gives quarter-rate phases at half duty. These overlap by a quarter period, which is the form a phase interpolator needs.
- Several eight-phase one-hot banks (`oct_ph`) give eighth-rate non-overlapping phases. Each bank can be restarted on its own, so that it can be aligned to a chosen coarse phase.

A common enable `en` gates every advance. A synchronous active-high reset `rst` starts every generator from a known pattern. Each generator has a valid flag that shows it has advanced at least once since its last reset.

Top module: `mph_clkgen`

## Requirements
- R1: Registered reset state, one clock after `rst` is sampled high:
  - `quad_np` is 4'b0001 (phase 0 active).
  - `quad_50` is 4'b0011 (phases 0 and 1 high).
  - every `oct_ph` bank is 8'b00000001.
  - `quad_vld` and all `oct_vld` bits are 0.
- R2: Each cycle with `en` high and no reset, `quad_np` moves its single set bit from index k to k+1, with index 3 wrapping to 0. Exactly one bit is set at all times after reset.
- R3: Each enabled cycle, `quad_50` rotates by one position toward the higher index. Exactly two bits are set, and they are at adjacent indices modulo 4, so each phase is high for 2 of every 4 enabled cycles.
- R4: A bit of `quad_np` is high only while the same-index bit of `quad_50` is high.
- R5: Each bank b of `oct_ph` occupies bits [8b+7:8b]. It holds exactly one set bit, which advances from index k to k+1 (7 wraps to 0) on every enabled cycle in which that bank is not being reset.
- R6: While `en` is low, every phase vector and every valid flag keeps its value.
- R7: `bank_rst[b]` high returns bank b to 8'b00000001 and clears `oct_vld[b]`. It leaves the other banks, `quad_np` and `quad_50` untouched.
- R8: `quad_vld` becomes 1 one clock after the first enabled cycle following `rst`. `oct_vld[b]` becomes 1 one clock after the first enabled cycle following the latest reset of bank b. Both stay 1 until the next reset.
- R9: `rst` or `bank_rst[b]` takes priority over `en` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast input clock, one edge per input period |
| rst | input | 1 | synchronous active-high reset of all generators |
| en | input | 1 | advance enable for all generators |
| bank_rst | input | N_BANK (4) | synchronous restart of each eighth-rate bank |
| quad_np | output | Q_PH (4) | non-overlapping quarter-rate phases |
| quad_50 | output | Q_PH (4) | half-duty quarter-rate phases |
| oct_ph | output | N_BANK*O_PH (32) | eighth-rate one-hot phases, bank b at bits [8b+7:8b] |
| quad_vld | output | 1 | quarter-rate generators have advanced since reset |
| oct_vld | output | N_BANK (4) | bank b has advanced since its last reset |

## Verification
A corrupted ring register reaches the ports at once, because the phase vectors are the state registers themselves. A lost or doubled bit shows on the very next sample as a wrong popcount or as a one-hot pulse outside its half-duty window. A wrong rotation direction or a missed enable shows one clock after the faulty step as a phase at the wrong index. A bank restart that leaks into a neighbour shows on that neighbour's next sample.

// File: rtl/mph_pkg.sv
package mph_pkg;

  // Default sizes shared by the generator and its checker.
  localparam int unsigned QUAD_PHASES = 4;
  localparam int unsigned OCT_PHASES  = 8;
  localparam int unsigned OCT_BANKS   = 4;

  // Seed pattern of a rotating register.
  typedef enum logic [0:0] {
    RING_ONEHOT = 1'b0,  // single bit set at index 0
    RING_HALF   = 1'b1   // lower half of the bits set
  } ring_kind_e;

endpackage

// File: rtl/mph_ring.sv
module mph_ring
  import mph_pkg::*;
#(
  parameter int unsigned W    = 4,
  parameter ring_kind_e  KIND = RING_ONEHOT
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] ph,
  output logic         vld
);

  localparam int unsigned HALF = W / 2;
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic [W-1:0] seed;

  generate
    if (KIND == RING_ONEHOT) begin : g_onehot
      assign seed = W'(1);
    end else begin : g_half
      assign seed = ALL_ONES >> (W - HALF);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= seed;
      vld <= 1'b0;
    end else if (adv) begin
      ph  <= {ph[W-2:0], ph[W-1]};
      vld <= 1'b1;
    end
  end

endmodule

// File: rtl/mph_octbank.sv
module mph_octbank
  import mph_pkg::*;
#(
  parameter int unsigned O_PH = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bank_rst,
  input  logic            en,
  output logic [O_PH-1:0] ph,
  output logic            vld
);

  logic restart;

  // A global or a local restart, both synchronous; either wins over en.
  assign restart = rst | bank_rst;

  mph_ring #(.W(O_PH), .KIND(RING_ONEHOT)) u_ring (
    .clk (clk),
    .rst (restart),
    .adv (en),
    .ph  (ph),
    .vld (vld)
  );

endmodule

// File: rtl/mph_clkgen.sv
module mph_clkgen
  import mph_pkg::*;
#(
  parameter int unsigned Q_PH   = QUAD_PHASES,
  parameter int unsigned O_PH   = OCT_PHASES,
  parameter int unsigned N_BANK = OCT_BANKS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic [N_BANK-1:0]      bank_rst,
  output logic [Q_PH-1:0]        quad_np,
  output logic [Q_PH-1:0]        quad_50,
  output logic [N_BANK*O_PH-1:0] oct_ph,
  output logic                   quad_vld,
  output logic [N_BANK-1:0]      oct_vld
);

  logic np_vld;
  logic h_vld;

  // Non-overlapping quarter-rate phases.
  mph_ring #(.W(Q_PH), .KIND(RING_ONEHOT)) u_np (
    .clk (clk),
    .rst (rst),
    .adv (en),
    .ph  (quad_np),
    .vld (np_vld)
  );

  // Half-duty quarter-rate phases, locked to the one-hot ring.
  mph_ring #(.W(Q_PH), .KIND(RING_HALF)) u_half (
    .clk (clk),
    .rst (rst),
    .adv (en),
    .ph  (quad_50),
    .vld (h_vld)
  );

  assign quad_vld = np_vld & h_vld;

  // Eighth-rate banks, each with its own restart.
  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    mph_octbank #(.O_PH(O_PH)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .bank_rst (bank_rst[b]),
      .en       (en),
      .ph       (oct_ph[b*O_PH +: O_PH]),
      .vld      (oct_vld[b])
    );
  end

endmodule

// File: rtl/mph_clkgen_chk.sv
module mph_clkgen_chk #(
  parameter int unsigned Q_PH   = 4,
  parameter int unsigned O_PH   = 8,
  parameter int unsigned N_BANK = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   en,
  input logic [N_BANK-1:0]      bank_rst,
  input logic [Q_PH-1:0]        quad_np,
  input logic [Q_PH-1:0]        quad_50,
  input logic [N_BANK*O_PH-1:0] oct_ph,
  input logic                   quad_vld,
  input logic [N_BANK-1:0]      oct_vld
);

  // R2: exactly one quarter phase active
  a_r2_np_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(quad_np) == 1);

  // R2: one-hot ring steps upward on enable
  a_r2_np_step: assert property (@(posedge clk) disable iff (rst)
    en |=> quad_np == {$past(quad_np[Q_PH-2:0]), $past(quad_np[Q_PH-1])});

  // R3: half of the quarter phases high
  a_r3_half_count: assert property (@(posedge clk) disable iff (rst)
    $countones(quad_50) == Q_PH / 2);

  // R3: half-duty generator steps upward on enable
  a_r3_half_step: assert property (@(posedge clk) disable iff (rst)
    en |=> quad_50 == {$past(quad_50[Q_PH-2:0]), $past(quad_50[Q_PH-1])});

  // R4: one-hot pulse lies inside its half-duty window
  a_r4_nest: assert property (@(posedge clk) disable iff (rst)
    (quad_np & ~quad_50) == '0);

  // R6: quarter outputs hold without enable
  a_r6_quad_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(quad_np) && $stable(quad_50) && $stable(quad_vld));

  // R8: quarter valid follows an enabled cycle
  a_r8_quad_vld: assert property (@(posedge clk) disable iff (rst)
    en |=> quad_vld);

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    // R5: exactly one eighth phase active per bank
    a_r5_oct_onehot: assert property (@(posedge clk) disable iff (rst || bank_rst[b])
      $countones(oct_ph[b*O_PH +: O_PH]) == 1);

    // R6: bank holds without enable
    a_r6_oct_hold: assert property (@(posedge clk) disable iff (rst)
      (!en && !bank_rst[b]) |=> $stable(oct_ph[b*O_PH +: O_PH]) && $stable(oct_vld[b]));

    // R7 / R9: bank restart lands on phase 0 with valid cleared
    a_r7_bank_restart: assert property (@(posedge clk) disable iff (rst)
      bank_rst[b] |=> (oct_ph[b*O_PH +: O_PH] == O_PH'(1)) && !oct_vld[b]);
  end

endmodule

bind mph_clkgen mph_clkgen_chk #(.Q_PH(Q_PH), .O_PH(O_PH), .N_BANK(N_BANK)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .bank_rst (bank_rst),
  .quad_np  (quad_np),
  .quad_50  (quad_50),
  .oct_ph   (oct_ph),
  .quad_vld (quad_vld),
  .oct_vld  (oct_vld)
);

// File: tb/test_mph_clkgen.sv
`timescale 1ns/1ps
module test_mph_clkgen;

  localparam int QP = 4;
  localparam int OP = 8;
  localparam int NB = 4;

  typedef struct {
    logic [QP-1:0]    np;
    logic [QP-1:0]    h;
    logic [NB*OP-1:0] oct;
    logic             qv;
    logic [NB-1:0]    ov;
    string            tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [NB-1:0] bank_rst = '0;
  logic [QP-1:0] quad_np, quad_50;
  logic [NB*OP-1:0] oct_ph;
  logic quad_vld;
  logic [NB-1:0] oct_vld;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  exp_t sb[$];

  // model state
  int qpos = 0;
  int opos[NB];
  logic mqv = 0;
  logic [NB-1:0] mov = '0;

  always #2 clk = ~clk;

  mph_clkgen i_mph_clkgen (
    .clk(clk), .rst(rst), .en(en), .bank_rst(bank_rst),
    .quad_np(quad_np), .quad_50(quad_50), .oct_ph(oct_ph),
    .quad_vld(quad_vld), .oct_vld(oct_vld)
  );

  function automatic exp_t model_out(string tag);
    exp_t e;
    e.np = QP'(1) << qpos;
    e.h = (QP'(1) << qpos) | (QP'(1) << ((qpos + 1) % QP));
    e.oct = '0;
    for (int b = 0; b < NB; b++) e.oct[b*OP + opos[b]] = 1'b1;
    e.qv = mqv;
    e.ov = mov;
    e.tag = tag;
    return e;
  endfunction

  // Driver: apply one cycle of stimulus, advance the model, queue the result.
  task automatic step(input logic r, input logic e, input logic [NB-1:0] br, input string tag);
    rst = r; en = e; bank_rst = br;
    if (r) begin
      qpos = 0; mqv = 0; mov = '0;
      for (int b = 0; b < NB; b++) opos[b] = 0;
    end else begin
      if (e) begin qpos = (qpos + 1) % QP; mqv = 1; end
      for (int b = 0; b < NB; b++) begin
        if (br[b]) begin opos[b] = 0; mov[b] = 0; end
        else if (e) begin opos[b] = (opos[b] + 1) % OP; mov[b] = 1; end
      end
    end
    sb.push_back(model_out(tag));
    @(negedge clk);
  endtask

  task automatic cmp(input string req, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s (%s): actual %h expected %h", req, tag, act, exp);
    end
  endtask

  // Monitor: compare outputs half a period after the edge.
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t x;
        x = sb.pop_front();
        cmp("R2", x.tag, 64'(quad_np), 64'(x.np));
        cmp("R3", x.tag, 64'(quad_50), 64'(x.h));
        cmp("R5", x.tag, 64'(oct_ph), 64'(x.oct));
        cmp("R8", x.tag, 64'({quad_vld, oct_vld}), 64'({x.qv, x.ov}));
        cmp("R4", x.tag, 64'(quad_np & ~quad_50), 64'(0));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #20000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    @(negedge clk);
    repeat (3) step(1, 1, '0, "R1 reset state, R9 reset beats en");
    for (int i = 0; i < 10; i++) step(0, 1, '0, "R2 R3 R5 free run with wrap");
    for (int i = 0; i < 3; i++) step(0, 0, '0, "R6 hold with en low");
    for (int i = 0; i < 8; i++) step(0, i[0], '0, "R6 alternating enable");
    step(0, 1, 4'b0100, "R7 R9 bank 2 restart during en");
    for (int i = 0; i < 3; i++) step(0, 1, '0, "R7 bank 2 realigned");
    step(0, 0, 4'b0001, "R7 bank 0 restart with en low");
    step(0, 0, '0, "R8 bank 0 valid stays low");
    step(0, 1, '0, "R8 bank 0 valid rises");
    step(0, 1, 4'b1010, "R7 two banks restart");
    for (int i = 0; i < 5; i++) step(0, 1, '0, "R5 banks offset");
    step(1, 0, '0, "R1 mid-run reset");
    step(0, 0, '0, "R8 valid low before first advance");
    for (int i = 0; i < 9; i++) step(0, 1, '0, "R2 R3 run after reset");
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule